// File: doc/BRIEF.md
# Glitch-free clock stop gate

This block sits after a clock source and hands a set of copies of that clock to the chip's output pins. Each copy can be halted and restarted on request without ever producing a shortened pulse. The output lanes fall into three groups. A CPU group answers to an active-low CPU stop request. A PCI group answers to its own active-low PCI stop request. A free-running group ignores both requests. Every lane also has its own enable bit, which stops that lane alone in the same way a group request would.

All request inputs (the two stop requests, the per-lane enables and the high-impedance control) are asynchronous. They pass through a synchronizer clocked by the source clock. Each lane holds a gate flop that updates on the falling edge of the source clock, so its value changes only while the source is low. The lane output is the source clock ANDed with that gate. As a result, a lane that stops keeps its last high phase at full width and then rests low, and a lane that restarts begins with a complete high phase. A per-lane output-enable flop, updated at the same point as the gate, drives every output enable low while high-impedance mode is requested.

Top module: `clkstop_gate`

## Requirements
- R1: A lane output is never high while the source clock is low; a stopped lane rests at logic 0.
- R2: Every high pulse on a lane output lasts exactly one full high phase of the source clock, including the last pulse before a stop and the first pulse after a restart.
- R3: A request input that changes while the source clock is low appears at the lanes on the third rising source edge after the change (SYNC_STAGES = 2 synchronizer flops, then the falling-edge gate). This is less than one source period after the synchronized request reaches the gate.
- R4: With cpu_stop_n = 0, lanes 0 to N_CPU-1 stop while the PCI and free-running lanes keep running.
- R5: With pci_stop_n = 0, lanes N_CPU to N_CPU+N_PCI-1 stop while the CPU lanes keep running.
- R6: The top N_FREE lanes keep toggling whatever the values of pci_stop_n and cpu_stop_n.
- R7: out_en[i] = 0 stops lane i alone, with the same latency as a group request; out_en[i] = 1 lets the lane follow its group.
- R8: With hiz_mode = 1, every bit of clk_oe is 0 whatever the gate state, and the lane clocks keep their gating. With hiz_mode = 0, every bit of clk_oe is 1.
- R9: While rst_n is low, every bit of clk_out and clk_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Running source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU lanes |
| pci_stop_n | input | 1 | Active-low stop request for the PCI lanes |
| out_en | input | N_CPU+N_PCI+N_FREE | Per-lane enable, 1 = lane may run |
| hiz_mode | input | 1 | 1 = drive every output enable low |
| clk_out | output | N_CPU+N_PCI+N_FREE | Gated clock lanes |
| clk_oe | output | N_CPU+N_PCI+N_FREE | Per-lane output enable for the pad |

## Verification
On every cycle the assertions check four things. Outputs are low whenever the source is low. The high-phase value of each lane equals its gate state, so pulses are never cut short. Each lane follows the synchronized group request and its enable bit one falling edge after they settle. The output enables track the synchronized high-impedance control. Only the bench scenarios can show the latency measured from the raw asynchronous pins to the pad-side clocks. They also show that each group is isolated from the others' requests over whole stop and restart sequences, and that pulse widths measured in time stay full across every transition.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [1:0] {
    GRP_CPU  = 2'd0,
    GRP_PCI  = 2'd1,
    GRP_FREE = 2'd2
  } lane_grp_e;

  // Lanes are laid out CPU first, then PCI, then free-running.
  function automatic lane_grp_e grp_of(input int idx, input int n_cpu, input int n_pci);
    if (idx < n_cpu) begin
      return GRP_CPU;
    end else if (idx < n_cpu + n_pci) begin
      return GRP_PCI;
    end
    return GRP_FREE;
  endfunction

endpackage

// File: rtl/clkstop_rst_sync.sv
module clkstop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int         WIDTH   = 4,
  parameter int         STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_d [STAGES];
  logic [WIDTH-1:0] stg_q [STAGES];

  always_comb begin
    stg_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= RST_VAL;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane (
  input  logic clk_src,
  input  logic rst_n,
  input  logic run_i,
  input  logic hiz_i,
  output logic clk_o,
  output logic oe_o,
  output logic gate_o
);

  logic gate_d;
  logic gate_q;
  logic oe_d;
  logic oe_q;
  logic upd_en;

  // Gate and enable move only on the falling edge, i.e. while the source is low.
  always_comb begin
    upd_en = (gate_q != run_i) || (oe_q == hiz_i);
    gate_d = upd_en ? run_i : gate_q;
    oe_d   = upd_en ? ~hiz_i : oe_q;
  end

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      gate_q <= gate_d;
      oe_q   <= oe_d;
    end
  end

  assign clk_o  = clk_src & gate_q;
  assign oe_o   = oe_q;
  assign gate_o = gate_q;

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int N_CPU       = 2,
  parameter int N_PCI       = 3,
  parameter int N_FREE      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk_src,
  input  logic                               rst_n,
  input  logic                               cpu_stop_n,
  input  logic                               pci_stop_n,
  input  logic [N_CPU+N_PCI+N_FREE-1:0]      out_en,
  input  logic                               hiz_mode,
  output logic [N_CPU+N_PCI+N_FREE-1:0]      clk_out,
  output logic [N_CPU+N_PCI+N_FREE-1:0]      clk_oe
);

  localparam int N_OUT  = N_CPU + N_PCI + N_FREE;
  localparam int SYNC_W = N_OUT + 3;
  localparam int B_CPU  = N_OUT;
  localparam int B_PCI  = N_OUT + 1;
  localparam int B_HIZ  = N_OUT + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, 1'b0, {N_OUT{1'b0}}};

  logic              rst_q;
  logic [SYNC_W-1:0] req_raw;
  logic [SYNC_W-1:0] req_s;
  logic [N_OUT-1:0]  en_s;
  logic              cpu_run_s;
  logic              pci_run_s;
  logic              hiz_s;
  logic [N_OUT-1:0]  lane_run;
  logic [N_OUT-1:0]  gate_vec;

  clkstop_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_src (clk_src),
    .rst_n   (rst_n),
    .rst_q   (rst_q)
  );

  assign req_raw = {hiz_mode, pci_stop_n, cpu_stop_n, out_en};

  clkstop_sync #(
    .WIDTH   (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk_src (clk_src),
    .rst_n   (rst_q),
    .async_i (req_raw),
    .sync_o  (req_s)
  );

  assign en_s      = req_s[N_OUT-1:0];
  assign cpu_run_s = req_s[B_CPU];
  assign pci_run_s = req_s[B_PCI];
  assign hiz_s     = req_s[B_HIZ];

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    localparam lane_grp_e GRP = grp_of(i, N_CPU, N_PCI);
    if (GRP == GRP_CPU) begin : g_cpu
      assign lane_run[i] = cpu_run_s & en_s[i];
    end else if (GRP == GRP_PCI) begin : g_pci
      assign lane_run[i] = pci_run_s & en_s[i];
    end else begin : g_free
      assign lane_run[i] = en_s[i];
    end

    clkstop_lane u_lane (
      .clk_src (clk_src),
      .rst_n   (rst_q),
      .run_i   (lane_run[i]),
      .hiz_i   (hiz_s),
      .clk_o   (clk_out[i]),
      .oe_o    (clk_oe[i]),
      .gate_o  (gate_vec[i])
    );
  end

endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int N_CPU  = 2,
  parameter int N_PCI  = 3,
  parameter int N_FREE = 1
) (
  input logic                          clk_src,
  input logic                          rst_q,
  input logic                          cpu_run_s,
  input logic                          pci_run_s,
  input logic                          hiz_s,
  input logic [N_CPU+N_PCI+N_FREE-1:0] en_s,
  input logic [N_CPU+N_PCI+N_FREE-1:0] gate_vec,
  input logic [N_CPU+N_PCI+N_FREE-1:0] clk_out,
  input logic [N_CPU+N_PCI+N_FREE-1:0] clk_oe
);

  localparam int N_OUT = N_CPU + N_PCI + N_FREE;

  // R1: nothing high while the source sits low
  p_low_with_src_r1: assert property (@(posedge clk_src) disable iff (!rst_q)
    clk_out == '0);

  // R2: high-phase value equals the gate held across that phase
  p_full_phase_r2: assert property (@(negedge clk_src) disable iff (!rst_q)
    clk_out == gate_vec);

  // R8: output enables follow the synchronized high-impedance control
  p_hiz_off_r8: assert property (@(negedge clk_src) disable iff (!rst_q)
    hiz_s |=> clk_oe == '0);
  p_hiz_on_r8: assert property (@(negedge clk_src) disable iff (!rst_q)
    !hiz_s |=> clk_oe == '1);

  // R9: quiet outputs during reset
  p_reset_quiet_r9: assert property (@(posedge clk_src)
    !rst_q |-> (clk_out == '0 && clk_oe == '0));

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane_chk
    // R7: a cleared enable stops the lane
    p_lane_off_r7: assert property (@(negedge clk_src) disable iff (!rst_q)
      !en_s[i] |=> !clk_out[i]);
    if (i < N_CPU) begin : g_cpu
      // R4
      p_cpu_stop_r4: assert property (@(negedge clk_src) disable iff (!rst_q)
        !cpu_run_s |=> !clk_out[i]);
      p_cpu_run_r4: assert property (@(negedge clk_src) disable iff (!rst_q)
        (cpu_run_s && en_s[i]) |=> clk_out[i]);
    end else if (i < N_CPU + N_PCI) begin : g_pci
      // R5
      p_pci_stop_r5: assert property (@(negedge clk_src) disable iff (!rst_q)
        !pci_run_s |=> !clk_out[i]);
      p_pci_run_r5: assert property (@(negedge clk_src) disable iff (!rst_q)
        (pci_run_s && en_s[i]) |=> clk_out[i]);
    end else begin : g_free
      // R6
      p_free_run_r6: assert property (@(negedge clk_src) disable iff (!rst_q)
        en_s[i] |=> clk_out[i]);
    end
  end

endmodule

bind clkstop_gate clkstop_gate_chk #(
  .N_CPU  (N_CPU),
  .N_PCI  (N_PCI),
  .N_FREE (N_FREE)
) chk_i (
  .clk_src   (clk_src),
  .rst_q     (rst_q),
  .cpu_run_s (cpu_run_s),
  .pci_run_s (pci_run_s),
  .hiz_s     (hiz_s),
  .en_s      (en_s),
  .gate_vec  (gate_vec),
  .clk_out   (clk_out),
  .clk_oe    (clk_oe)
);

// File: tb/clkstop_gate_tb_top.sv
`timescale 1ns/1ps
module clkstop_gate_tb_top;

  localparam int  N_CPU      = 2;
  localparam int  N_PCI      = 3;
  localparam int  N_FREE     = 1;
  localparam int  N_OUT      = N_CPU + N_PCI + N_FREE;
  localparam int  CLK_PERIOD = 10;
  localparam real HALF       = CLK_PERIOD / 2.0;
  localparam logic [N_OUT-1:0] M_CPU  = 6'b000011;
  localparam logic [N_OUT-1:0] M_PCI  = 6'b011100;
  localparam logic [N_OUT-1:0] M_FREE = 6'b100000;

  logic             clk_src;
  logic             rst_n;
  logic             cpu_stop_n;
  logic             pci_stop_n;
  logic [N_OUT-1:0] out_en;
  logic             hiz_mode;
  logic [N_OUT-1:0] clk_out;
  logic [N_OUT-1:0] clk_oe;

  int  n_checks;
  int  n_fail;
  bit  done;
  int  runt_cnt [N_OUT];
  real t_rise   [N_OUT];

  clkstop_gate #(
    .N_CPU  (N_CPU),
    .N_PCI  (N_PCI),
    .N_FREE (N_FREE)
  ) dut_i (
    .clk_src    (clk_src),
    .rst_n      (rst_n),
    .cpu_stop_n (cpu_stop_n),
    .pci_stop_n (pci_stop_n),
    .out_en     (out_en),
    .hiz_mode   (hiz_mode),
    .clk_out    (clk_out),
    .clk_oe     (clk_oe)
  );

  initial begin
    clk_src = 1'b0;
    forever #(CLK_PERIOD / 2) clk_src = ~clk_src;
  end

  // Pulse-width monitor per lane (R2)
  for (genvar i = 0; i < N_OUT; i++) begin : g_mon
    initial begin
      runt_cnt[i] = 0;
      t_rise[i]   = 0.0;
    end
    always @(posedge clk_out[i]) t_rise[i] = $realtime;
    always @(negedge clk_out[i]) begin
      if (($realtime - t_rise[i]) > HALF + 0.01 || ($realtime - t_rise[i]) < HALF - 0.01)
        runt_cnt[i] = runt_cnt[i] + 1;
    end
  end

  task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_low_phase();
    @(negedge clk_src);
    #1;
  endtask

  task automatic at_high();
    @(posedge clk_src);
    #2;
  endtask

  // Drive, then expect old value for two rising edges and new on the third (R3)
  task automatic expect_switch(input string req, input logic [N_OUT-1:0] old_v, input logic [N_OUT-1:0] new_v);
    at_high(); check({req, " R3 edge1"}, clk_out, old_v);
    at_high(); check({req, " R3 edge2"}, clk_out, old_v);
    at_high(); check({req, " R3 edge3"}, clk_out, new_v);
    at_high(); check({req, " hold"}, clk_out, new_v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; out_en = '1; hiz_mode = 1'b0;
    repeat (3) at_high();
    check("R9 clk_out in reset", clk_out, '0);
    check("R9 clk_oe in reset", clk_oe, '0);
    drive_low_phase();
    rst_n = 1'b1;
    repeat (6) at_high();
  endtask

  task automatic t_run_all();
    at_high();
    check("R1 all running high phase", clk_out, '1);
    check("R8 oe on", clk_oe, '1);
    drive_low_phase();
    #2;
    check("R1 low phase", clk_out, '0);
  endtask

  task automatic t_cpu_stop();
    drive_low_phase(); cpu_stop_n = 1'b0;
    expect_switch("R4 cpu stop", '1, ~M_CPU);
    drive_low_phase(); #2;
    check("R1 parked low", clk_out, '0);
    cpu_stop_n = 1'b1;
    expect_switch("R4 cpu restart", ~M_CPU, '1);
  endtask

  task automatic t_pci_stop();
    drive_low_phase(); pci_stop_n = 1'b0;
    expect_switch("R5 R6 pci stop", '1, ~M_PCI);
    check("R6 free lane runs", clk_out & M_FREE, M_FREE);
    drive_low_phase(); cpu_stop_n = 1'b0;
    expect_switch("R6 both stopped", ~M_PCI, M_FREE);
    drive_low_phase(); pci_stop_n = 1'b1; cpu_stop_n = 1'b1;
    expect_switch("R5 restart", M_FREE, '1);
  endtask

  task automatic t_lane_disable();
    drive_low_phase(); out_en = 6'b111101;
    expect_switch("R7 lane1 off", '1, 6'b111101);
    drive_low_phase(); out_en = 6'b011111;
    expect_switch("R7 free lane off", 6'b111101, 6'b011111);
    drive_low_phase(); out_en = '1;
    expect_switch("R7 re-enable", 6'b011111, '1);
  endtask

  task automatic t_hiz();
    drive_low_phase(); hiz_mode = 1'b1;
    at_high(); check("R8 oe edge1", clk_oe, '1);
    at_high(); check("R8 oe edge2", clk_oe, '1);
    at_high(); check("R8 oe off", clk_oe, '0);
    check("R8 clocks keep gating", clk_out, '1);
    drive_low_phase(); hiz_mode = 1'b0;
    repeat (3) at_high();
    check("R8 oe back on", clk_oe, '1);
  endtask

  task automatic t_widths();
    int total;
    total = 0;
    for (int i = 0; i < N_OUT; i++) total += runt_cnt[i];
    check("R2 runt pulses", total[N_OUT-1:0], '0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    t_reset();
    t_run_all();
    t_cpu_stop();
    t_pci_stop();
    t_lane_disable();
    t_hiz();
    repeat (2) at_high();
    t_widths();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule